// File: doc/BRIEF.md
# MDIO Management Bus Master

This block runs single register transactions on a two-wire PHY management bus. It produces the management clock (MDC) and drives the bidirectional data line through a separate output value and output enable; the pad logic outside resolves the enable. A host hands over one request at a time: a read or write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The request is accepted with a valid/ready handshake. Completion is a one-cycle `done_o` pulse that carries the read data and an error flag.

Each transaction is a sequence of bit slots. A slot is an MDC low phase followed by an MDC high phase, and each phase lasts H system clocks. H is the value of `half_div_i` taken at acceptance, with zero treated as one. The master changes the line only at the start of a low phase. It reads the line on the last system clock of a high phase. On a read the PHY must pull the turnaround bit low. If it does not, the master clocks a recovery run with the line released and reports an error in place of data.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no transaction is in progress, `req_ready_o` is 1, `mdc_o` is 1, `mdio_oe_o` is 0 and `mdio_o` is 0.
- R2: A transaction opens with 32 slots in which the line is driven to 1. Every slot is H system clocks with `mdc_o` at 0 and then H clocks with `mdc_o` at 1. H is `half_div_i` sampled at acceptance, or 1 when that value is 0, and the first low clock is the cycle right after acceptance.
- R3: The next four driven slots are the start pattern 0,1 followed by the opcode: 1,0 for a read (`req_read_i`=1) or 0,1 for a write.
- R4: The next ten driven slots carry the PHY address and then the register address, each most significant bit first.
- R5: While the line stays driven, `mdio_o` changes only in a cycle where `mdc_o` is 0.
- R6: For a write, the master drives turnaround 1,0 and then the 16 data bits MSB first. It then spends one more slot with the line released, and completes with `err_o`=0 and `rd_data_o`=0.
- R7: For a read, the line is released from the first turnaround slot until completion. `mdio_i` is sampled on the last clock of that slot's high phase, and a value of 0 lets the read continue.
- R8: For a read with a good turnaround, the master samples 16 further slots at the last clock of each high phase, MSB first. After two trailing slots it completes with the assembled `rd_data_o` and `err_o`=0.
- R9: For a read whose turnaround sample is 1, the master clocks 32 recovery slots with the line released and completes with `err_o`=1 and `rd_data_o`=0.
- R10: `done_o` is high for exactly the one cycle after the final high phase. `rd_data_o` and `err_o` change only together with `done_o` and hold their values until the next completion.
- R11: A request is accepted only when `req_ready_o` is 1. A `req_valid_i` raised during a transaction has no effect. Request fields and `half_div_i` may change after acceptance without affecting the transaction.
- R12: A synchronous active-high `rst` aborts any transaction and restores the R1 state, with `rd_data_o` and `err_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | High when idle and able to accept a request |
| req_read_i | input | 1 | 1 for a read request, 0 for a write |
| req_phy_i | input | ADDR_W | PHY address |
| req_reg_i | input | ADDR_W | Register address |
| req_wdata_i | input | DATA_W | Write data |
| half_div_i | input | DIV_W | MDC half-period in system clocks (0 means 1) |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | DATA_W | Read result, held between completions |
| err_o | output | 1 | Turnaround error flag, held between completions |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench builds the block with `DIV_W` set to 4 and every other parameter at its default. This puts the full divider range in reach, from the zero setting that collapses to one clock per phase up to the widest half-period of 15 clocks, and every request still finishes in a few thousand cycles. Within that range the bench covers writes, good reads, failed-turnaround reads, requests raised while busy, and a reset in the middle of a frame. While the master reads, the bench's PHY model drives the inverse of each bit during the low phase, so a sample taken on any clock other than the last clock of the high phase returns wrong data.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

   // Frame section that the current slot belongs to
   typedef enum logic [2:0] {
      SEC_PRE,
      SEC_HDR,
      SEC_TA,
      SEC_WDATA,
      SEC_RDATA,
      SEC_TAIL,
      SEC_RECOV
   } sec_e;

endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] half_q;
   logic [DIV_W-1:0] cnt_q;

   assign tick_o = run_i && (cnt_q == half_q - DIV_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         half_q <= DIV_W'(1);
         cnt_q  <= '0;
      end else if (start_i) begin
         half_q <= (div_i == '0) ? DIV_W'(1) : div_i;
         cnt_q  <= '0;
      end else if (run_i) begin
         cnt_q <= tick_o ? '0 : cnt_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/mdio_slot_decode.sv
module mdio_slot_decode
   import mdio_master_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 16,
   parameter int PRE_LEN = 32,
   parameter int SLOT_W  = 7
) (
   input  logic [SLOT_W-1:0] slot_i,
   input  logic              rd_i,
   input  logic              recov_i,
   input  logic [ADDR_W-1:0] phy_i,
   input  logic [ADDR_W-1:0] reg_i,
   input  logic [DATA_W-1:0] wdata_i,
   output sec_e              sec_o,
   output logic              oe_o,
   output logic              bit_o
);

   localparam int HDR_W   = 4 + 2 * ADDR_W;
   localparam int TA_SLOT = PRE_LEN + HDR_W;

   logic [HDR_W-1:0] hdr_v;
   int               s;

   assign hdr_v = {2'b01, (rd_i ? 2'b10 : 2'b01), phy_i, reg_i};

   always_comb begin
      s     = int'(slot_i);
      sec_o = SEC_PRE;
      oe_o  = 1'b1;
      bit_o = 1'b1;
      if (s < PRE_LEN) begin
         sec_o = SEC_PRE;
      end else if (s < TA_SLOT) begin
         sec_o = SEC_HDR;
         bit_o = |(hdr_v & (HDR_W'(1) << (HDR_W - 1 - (s - PRE_LEN))));
      end else if (!rd_i) begin
         if (s < TA_SLOT + 2) begin
            sec_o = SEC_TA;
            bit_o = (s == TA_SLOT);
         end else if (s < TA_SLOT + 2 + DATA_W) begin
            sec_o = SEC_WDATA;
            bit_o = |(wdata_i & (DATA_W'(1) << (DATA_W - 1 - (s - TA_SLOT - 2))));
         end else begin
            sec_o = SEC_TAIL;
            oe_o  = 1'b0;
            bit_o = 1'b0;
         end
      end else begin
         oe_o  = 1'b0;
         bit_o = 1'b0;
         if (s == TA_SLOT)              sec_o = SEC_TA;
         else if (recov_i)              sec_o = SEC_RECOV;
         else if (s <= TA_SLOT + DATA_W) sec_o = SEC_RDATA;
         else                           sec_o = SEC_TAIL;
      end
   end

endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr_i,
   input  logic              shift_i,
   input  logic              bit_i,
   output logic [DATA_W-1:0] data_o
);

   always_ff @(posedge clk) begin
      if (rst || clr_i)  data_o <= '0;
      else if (shift_i)  data_o <= {data_o[DATA_W-2:0], bit_i};
   end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_master_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 16,
   parameter int DIV_W     = 8,
   parameter int PRE_LEN   = 32,
   parameter int RECOV_LEN = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic              req_read_i,
   input  logic [ADDR_W-1:0] req_phy_i,
   input  logic [ADDR_W-1:0] req_reg_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   input  logic [DIV_W-1:0]  half_div_i,
   output logic              done_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              err_o,
   output logic              mdc_o,
   output logic              mdio_o,
   output logic              mdio_oe_o,
   input  logic              mdio_i
);

   localparam int HDR_W    = 4 + 2 * ADDR_W;
   localparam int TA_SLOT  = PRE_LEN + HDR_W;
   localparam int LAST_WR  = TA_SLOT + 2 + DATA_W;
   localparam int LAST_RD  = TA_SLOT + DATA_W + 2;
   localparam int LAST_ERR = TA_SLOT + RECOV_LEN;
   localparam int MAX_A    = (LAST_WR > LAST_RD) ? LAST_WR : LAST_RD;
   localparam int MAX_LAST = (MAX_A > LAST_ERR) ? MAX_A : LAST_ERR;
   localparam int SLOT_W   = $clog2(MAX_LAST + 1);

   // elaboration-time parameter checks
   if (ADDR_W < 1)    begin : g_bad_addr  $error("ADDR_W must be at least 1");  end
   if (DATA_W < 2)    begin : g_bad_data  $error("DATA_W must be at least 2");  end
   if (DIV_W < 1)     begin : g_bad_div   $error("DIV_W must be at least 1");   end
   if (PRE_LEN < 1)   begin : g_bad_pre   $error("PRE_LEN must be at least 1"); end
   if (RECOV_LEN < 1) begin : g_bad_recov $error("RECOV_LEN must be at least 1"); end

   logic              busy_q, phase_q, rd_q, recov_q, done_q, err_q;
   logic [SLOT_W-1:0] slot_q, last_slot;
   logic [ADDR_W-1:0] phy_q, reg_q;
   logic [DATA_W-1:0] wd_q, rd_data_q, shift_data;
   logic              tick, accept, end_high, at_last, ta_fail;
   logic              dec_oe, dec_bit;
   sec_e              sec;

   assign accept   = req_valid_i && !busy_q;
   assign end_high = busy_q && tick && phase_q;

   always_comb begin
      if (!rd_q)        last_slot = SLOT_W'(LAST_WR);
      else if (recov_q) last_slot = SLOT_W'(LAST_ERR);
      else              last_slot = SLOT_W'(LAST_RD);
   end

   assign at_last = (slot_q == last_slot);
   assign ta_fail = end_high && rd_q && (sec == SEC_TA) && mdio_i;

   mdio_half_timer #(.DIV_W(DIV_W)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .start_i (accept),
      .run_i   (busy_q),
      .div_i   (half_div_i),
      .tick_o  (tick)
   );

   mdio_slot_decode #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .PRE_LEN (PRE_LEN),
      .SLOT_W  (SLOT_W)
   ) u_decode (
      .slot_i  (slot_q),
      .rd_i    (rd_q),
      .recov_i (recov_q),
      .phy_i   (phy_q),
      .reg_i   (reg_q),
      .wdata_i (wd_q),
      .sec_o   (sec),
      .oe_o    (dec_oe),
      .bit_o   (dec_bit)
   );

   mdio_rx_shift #(.DATA_W(DATA_W)) u_rx (
      .clk     (clk),
      .rst     (rst),
      .clr_i   (accept),
      .shift_i (end_high && (sec == SEC_RDATA)),
      .bit_i   (mdio_i),
      .data_o  (shift_data)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q    <= 1'b0;
         phase_q   <= 1'b0;
         slot_q    <= '0;
         rd_q      <= 1'b0;
         recov_q   <= 1'b0;
         phy_q     <= '0;
         reg_q     <= '0;
         wd_q      <= '0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
         rd_data_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            slot_q  <= '0;
            recov_q <= 1'b0;
            rd_q    <= req_read_i;
            phy_q   <= req_phy_i;
            reg_q   <= req_reg_i;
            wd_q    <= req_wdata_i;
         end else if (busy_q && tick) begin
            if (!phase_q) begin
               phase_q <= 1'b1;
            end else begin
               if (ta_fail) recov_q <= 1'b1;
               phase_q <= 1'b0;
               if (at_last) begin
                  busy_q    <= 1'b0;
                  done_q    <= 1'b1;
                  err_q     <= recov_q;
                  rd_data_q <= (rd_q && !recov_q) ? shift_data : '0;
               end else begin
                  slot_q <= slot_q + SLOT_W'(1);
               end
            end
         end
      end
   end

   assign req_ready_o = !busy_q;
   assign mdc_o       = !busy_q || phase_q;
   assign mdio_oe_o   = busy_q && dec_oe;
   assign mdio_o      = busy_q && dec_oe && dec_bit;
   assign done_o      = done_q;
   assign err_o       = err_q;
   assign rd_data_o   = rd_data_q;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid_i,
   input logic              req_ready_o,
   input logic              done_o,
   input logic [DATA_W-1:0] rd_data_o,
   input logic              err_o,
   input logic              mdc_o,
   input logic              mdio_o,
   input logic              mdio_oe_o
);

   // R1
   idle_line_chk: assert property (@(posedge clk) disable iff (rst)
      req_ready_o |-> (mdc_o && !mdio_oe_o));

   // R2
   first_slot_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid_i && req_ready_o) |=> (!mdc_o && mdio_oe_o && mdio_o && !req_ready_o));

   // R5
   change_low_chk: assert property (@(posedge clk) disable iff (rst)
      (mdio_oe_o && $past(mdio_oe_o) && (mdio_o != $past(mdio_o))) |-> !mdc_o);

   // R9
   err_nodata_chk: assert property (@(posedge clk) disable iff (rst)
      (done_o && err_o) |-> (rd_data_o == '0));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!done_o && !$past(rst)) |-> ($stable(rd_data_o) && $stable(err_o)));

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |-> req_ready_o);

endmodule

bind mdio_master mdio_master_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .req_valid_i (req_valid_i),
   .req_ready_o (req_ready_o),
   .done_o      (done_o),
   .rd_data_o   (rd_data_o),
   .err_o       (err_o),
   .mdc_o       (mdc_o),
   .mdio_o      (mdio_o),
   .mdio_oe_o   (mdio_oe_o)
);

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid_i = 1'b0;
   logic        req_read_i = 1'b0;
   logic [4:0]  req_phy_i = '0;
   logic [4:0]  req_reg_i = '0;
   logic [15:0] req_wdata_i = '0;
   logic [3:0]  half_div_i = '0;
   logic        mdio_i = 1'b1;
   logic        req_ready_o, done_o, err_o, mdc_o, mdio_o, mdio_oe_o;
   logic [15:0] rd_data_o;

   always #2 clk = ~clk;

   mdio_master #(.DIV_W(4)) u_mdio_master (
      .clk         (clk),
      .rst         (rst),
      .req_valid_i (req_valid_i),
      .req_ready_o (req_ready_o),
      .req_read_i  (req_read_i),
      .req_phy_i   (req_phy_i),
      .req_reg_i   (req_reg_i),
      .req_wdata_i (req_wdata_i),
      .half_div_i  (half_div_i),
      .done_o      (done_o),
      .rd_data_o   (rd_data_o),
      .err_o       (err_o),
      .mdc_o       (mdc_o),
      .mdio_o      (mdio_o),
      .mdio_oe_o   (mdio_oe_o),
      .mdio_i      (mdio_i)
   );

   typedef struct {
      bit          mdc;
      bit          oe;
      bit          o;
      bit          mi;
      bit          done;
      logic [15:0] rd;
      bit          err;
   } exp_t;

   exp_t        q[$];
   string       qt[$];
   int          n_cmp = 0;
   int          n_bad = 0;
   int          cyc = 0;
   bit          fin = 1'b0;
   logic [15:0] last_rd = '0;
   bit          last_err = 1'b0;

   task automatic summary();
      if (!fin) begin
         fin = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic push(bit mdc, bit oe, bit o, bit mi, bit done,
                       logic [15:0] rd, bit err, string tag);
      exp_t e;
      e.mdc = mdc; e.oe = oe; e.o = o; e.mi = mi; e.done = done; e.rd = rd; e.err = err;
      q.push_back(e);
      qt.push_back(tag);
   endtask

   // behavioural reference: expected port values for every clock of a transaction
   task automatic build(bit rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd,
                        logic [3:0] div, bit ta_bad, logic [15:0] rdv);
      int          h;
      int          nslots;
      logic [13:0] hdr;
      h      = (div == 0) ? 1 : int'(div);
      hdr    = {2'b01, (rd ? 2'b10 : 2'b01), phy, rg};
      nslots = (rd && ta_bad) ? 79 : 65;
      for (int s = 0; s < nslots; s++) begin
         bit    oe, o, dv, phy_drv;
         string tag;
         oe = 1'b1; o = 1'b1; dv = 1'b1; phy_drv = 1'b0; tag = "R2";
         if (s < 32) begin
            tag = "R2";                              // preamble, R2
         end else if (s < 46) begin
            o   = hdr[13 - (s - 32)];
            tag = (s < 36) ? "R3" : "R4";            // start/opcode R3, addresses R4
         end else if (!rd) begin
            tag = "R6";
            if (s == 46)      o = 1'b1;
            else if (s == 47) o = 1'b0;
            else if (s < 64)  o = wd[15 - (s - 48)];
            else begin oe = 1'b0; o = 1'b0; end
         end else begin
            oe = 1'b0; o = 1'b0;
            if (s == 46) begin
               tag = "R7"; dv = ta_bad; phy_drv = 1'b1;
            end else if (ta_bad) begin
               tag = "R9";
            end else if (s <= 62) begin
               tag = "R8"; dv = rdv[15 - (s - 47)]; phy_drv = 1'b1;
            end else begin
               tag = "R8";
            end
         end
         for (int k = 0; k < h; k++)
            push(1'b0, oe, o, phy_drv ? ~dv : 1'b1, 1'b0, '0, 1'b0, tag);
         for (int k = 0; k < h; k++)
            push(1'b1, oe, o, phy_drv ? dv : 1'b1, 1'b0, '0, 1'b0, tag);
      end
      // R10 completion cycle
      push(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, (rd && !ta_bad) ? rdv : 16'h0000,
           rd && ta_bad, "R10");
   endtask

   task automatic do_reset();
      @(negedge clk); #1;
      rst = 1'b1;
      q.delete(); qt.delete();
      last_rd = '0; last_err = 1'b0;
      repeat (3) @(negedge clk);
      #1 rst = 1'b0;
   endtask

   task automatic run_txn(bit rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd,
                          logic [3:0] div, bit ta_bad, logic [15:0] rdv,
                          bit poke, int abort_after);
      @(negedge clk); #1;
      req_read_i = rd; req_phy_i = phy; req_reg_i = rg; req_wdata_i = wd;
      half_div_i = div; req_valid_i = 1'b1;
      build(rd, phy, rg, wd, div, ta_bad, rdv);
      @(posedge clk); #1;
      // R11: fields and divider change after acceptance
      req_valid_i = 1'b0;
      req_read_i = ~rd; req_phy_i = ~phy; req_reg_i = ~rg; req_wdata_i = ~wd;
      half_div_i = div ^ 4'h5;
      if (poke) begin
         repeat (10) @(posedge clk);
         #1 req_valid_i = 1'b1;             // R11: request while busy is ignored
         repeat (4) @(posedge clk);
         #1 req_valid_i = 1'b0;
      end
      if (abort_after > 0) begin
         repeat (abort_after) @(posedge clk);
         do_reset();                        // R12
      end else begin
         while (q.size() != 0) begin @(negedge clk); #1; end
      end
      repeat (3) @(negedge clk);
   endtask

   // per-clock comparison against the reference queue
   always @(negedge clk) begin
      if (!rst && !fin) begin
         exp_t  e;
         string t;
         bit    bad;
         if (q.size() > 0) begin
            e = q.pop_front();
            t = qt.pop_front();
            mdio_i = e.mi;
            bad = (mdc_o !== e.mdc) || (mdio_oe_o !== e.oe) ||
                  (e.oe && (mdio_o !== e.o)) ||
                  (req_ready_o !== e.done) || (done_o !== e.done);
            if (e.done) begin
               bad = bad || (rd_data_o !== e.rd) || (err_o !== e.err);
               last_rd = e.rd; last_err = e.err;
            end else begin
               bad = bad || (rd_data_o !== last_rd) || (err_o !== last_err);
            end
            n_cmp++;
            if (bad) begin
               n_bad++;
               $display("FAIL %s t=%0t actual mdc/oe/o/rdy/done=%b%b%b%b%b rd=%h err=%b expected mdc/oe/o/rdy/done=%b%b%b%b%b rd=%h err=%b",
                        t, $time, mdc_o, mdio_oe_o, mdio_o, req_ready_o, done_o, rd_data_o, err_o,
                        e.mdc, e.oe, e.o, e.done, e.done, e.done ? e.rd : last_rd,
                        e.done ? e.err : last_err);
            end
         end else begin
            // R1 idle state, R10 held results
            mdio_i = 1'b1;
            n_cmp++;
            if (mdc_o !== 1'b1 || mdio_oe_o !== 1'b0 || mdio_o !== 1'b0 ||
                req_ready_o !== 1'b1 || done_o !== 1'b0 ||
                rd_data_o !== last_rd || err_o !== last_err) begin
               n_bad++;
               $display("FAIL R1 t=%0t idle actual mdc/oe/o/rdy/done=%b%b%b%b%b rd=%h err=%b expected 10010 rd=%h err=%b",
                        $time, mdc_o, mdio_oe_o, mdio_o, req_ready_o, done_o, rd_data_o, err_o,
                        last_rd, last_err);
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !fin) begin
         n_cmp++; n_bad++;
         $display("FAIL R11 watchdog actual=hung expected=finished");
         summary();
      end
   end

   initial begin
      // R12 initial reset, R1 idle after it
      repeat (4) @(negedge clk);
      #1 rst = 1'b0;
      repeat (5) @(negedge clk);
      // R6 write, H=1
      run_txn(1'b0, 5'h01, 5'h00, 16'hA5C3, 4'd1, 1'b0, 16'h0000, 1'b0, 0);
      // R7 R8 good read, H=2
      run_txn(1'b1, 5'h1F, 5'h15, 16'h0000, 4'd2, 1'b0, 16'h8001, 1'b0, 0);
      // R9 failed turnaround, divider 0 acts as H=1
      run_txn(1'b1, 5'h0A, 5'h03, 16'h0000, 4'd0, 1'b1, 16'hFFFF, 1'b0, 0);
      // R11 write with request poke while busy, H=3
      run_txn(1'b0, 5'h10, 5'h01, 16'h0000, 4'd3, 1'b0, 16'h0000, 1'b1, 0);
      // R8 R11 good read with poke
      run_txn(1'b1, 5'h00, 5'h1F, 16'h0000, 4'd1, 1'b0, 16'h5A3C, 1'b1, 0);
      // R9 R11 failed turnaround with poke, H=2
      run_txn(1'b1, 5'h15, 5'h0A, 16'h0000, 4'd2, 1'b1, 16'h0000, 1'b1, 0);
      // R2 R6 widest half-period
      run_txn(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 4'd15, 1'b0, 16'h0000, 1'b0, 0);
      // R12 reset mid-frame
      run_txn(1'b0, 5'h02, 5'h04, 16'h1234, 4'd1, 1'b0, 16'h0000, 1'b0, 40);
      repeat (4) @(negedge clk);
      // R8 read after reset
      run_txn(1'b1, 5'h03, 5'h07, 16'h0000, 4'd1, 1'b0, 16'h0F0F, 1'b0, 0);
      // R8 read of all zeros, divider 0
      run_txn(1'b1, 5'h11, 5'h12, 16'h0000, 4'd0, 1'b0, 16'h0000, 1'b0, 0);
      repeat (5) @(negedge clk);
      summary();
   end

endmodule